// File: doc/BRIEF.md
# Broadcasting Banked Memory Crossbar

This block sits between a cluster of processor cores and a set of interleaved memory banks. Each core raises a request with a word address and, for a store, a data word. In the same cycle the crossbar decodes the address, picks the target bank, settles any contention and returns read data. There is no register between the request and the response, so a request that is accepted completes in one cycle. The same block serves an instruction memory and a data memory.

The top address bit selects a region. Region 0 is shared and is interleaved across the banks by the low address bits. Region 1 is private: it goes to a dedicated port owned by the requesting core, so it never contends with anything. When several cores ask the same bank for different words, a round-robin arbiter on that bank admits one of them and the others see ready held low. Cores that read the very same word in the same cycle are served together. The bank performs one access and the word is handed to each of those cores, each with its own response strobe. Stores are never combined.

Back-pressure rules: a core drives `core_valid` together with its address, store flag and data, and holds them unchanged until it sees `core_ready` high at a clock edge. `core_ready` is the grant. It is high only while `core_valid` is high. A read response appears on `rsp_valid`/`rsp_rdata` in the same cycle as the grant and cannot be back-pressured. A core that does not see ready is stalled.

Top module: `bcast_bank_xbar`

## Requirements
- R1: A shared-region address (bit AW-1 = 0) selects bank `addr[log2(M)-1:0]` and presents `addr[AW-2:log2(M)]` as the in-bank word address on that bank's port.
- R2: A private-region address (bit AW-1 = 1) is routed only to the requesting core's private port with in-port address `addr[AW-2:0]`. It is granted in the same cycle whatever the shared banks are doing, and it enables no shared bank.
- R3: A granted read has its response strobe high and carries the addressed word in the same cycle as the grant. A store or a stalled request produces no response strobe.
- R4: When requests to one bank carry different addresses, exactly one of them is granted in a cycle and the rest see ready low.
- R5: Each bank has a round-robin pointer that starts at core 0 after reset. The search for a winner begins at the pointer, and after each bank access the pointer moves to the core just after the winner.
- R6: Reads from several cores to the identical shared address in one cycle cause a single bank access. All of those cores are granted together and receive the same word, each with its own response strobe.
- R7: Stores are never merged. When a store wins a bank, no other core is granted on that bank in that cycle, even a read or store to the same word. When a read wins, a store to the same word stalls.
- R8: Requests to different banks in the same cycle are all granted in that cycle.
- R9: A request held stable while stalled is granted within N cycles.
- R10: After reset, and whenever there are no requests, no ready, response strobe, bank enable or private enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid | input | N | Request valid per core |
| core_ready | output | N | Grant per core; low while valid means stall |
| core_we | input | N | Store flag per core |
| core_addr | input | N x AW | Word address per core; MSB selects the private region |
| core_wdata | input | N x DW | Store data per core |
| rsp_valid | output | N | Read response strobe per core |
| rsp_rdata | output | N x DW | Read data per core |
| bank_en | output | M | Shared bank access enable |
| bank_we | output | M | Shared bank write enable |
| bank_addr | output | M x (AW-1-log2 M) | In-bank word address |
| bank_wdata | output | M x DW | Shared bank write data |
| bank_rdata | input | M x DW | Shared bank read data, combinational |
| priv_en | output | N | Private port access enable |
| priv_we | output | N | Private port write enable |
| priv_addr | output | N x (AW-1) | Private port word address |
| priv_wdata | output | N x DW | Private port write data |
| priv_rdata | input | N x DW | Private port read data, combinational |

## Verification
Merging and arbitration can both act on one bank in the same cycle. In that case one group of cores reading a shared word is granted as a block while another core, reading a different word in that bank, is stalled. The bench sets this up with a mixed request pattern on one bank. It then checks the exact ready mask, that only that bank is enabled, and the broadcast word for every member of the group. A store contending with reads of the same word is a second such case. The bench drives it in both pointer orders and judges it by the ready mask, the absence of response strobes for the store, and the word read back in the following cycle.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
  typedef enum logic {
    RGN_SHARED  = 1'b0,
    RGN_PRIVATE = 1'b1
  } bbx_region_e;
endpackage

// File: rtl/bbx_req_decode.sv
module bbx_req_decode #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int AW = 8
) (
  input  logic [N-1:0][AW-1:0]             core_addr,
  output logic [N-1:0]                     is_priv,
  output logic [N-1:0][$clog2(M)-1:0]      bank_idx,
  output logic [N-1:0][AW-2-$clog2(M):0]   shr_off,
  output logic [N-1:0][AW-2:0]             prv_off
);
  import bbx_pkg::*;
  localparam int BANK_W = $clog2(M);

  for (genvar i = 0; i < N; i++) begin : g_core
    assign is_priv[i]  = (bbx_region_e'(core_addr[i][AW-1]) == RGN_PRIVATE);
    assign bank_idx[i] = core_addr[i][BANK_W-1:0];
    assign shr_off[i]  = core_addr[i][AW-2:BANK_W];
    assign prv_off[i]  = core_addr[i][AW-2:0];
  end
endmodule

// File: rtl/bbx_rr_arbiter.sv
module bbx_rr_arbiter #(
  parameter int N = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N-1:0]                       req,
  output logic [N-1:0]                       win_oh,
  output logic [(N > 1 ? $clog2(N) : 1)-1:0] win_idx,
  output logic                               any
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] ptr_q;
  int               cand;

  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    any     = 1'b0;
    cand    = 0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(ptr_q) + k) % N;
      if (!any && req[cand]) begin
        any          = 1'b1;
        win_oh[cand] = 1'b1;
        win_idx      = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (any) begin
      ptr_q <= (win_idx == IDX_W'(N - 1)) ? '0 : win_idx + 1'b1;
    end
  end
endmodule

// File: rtl/bbx_bank_slice.sv
module bbx_bank_slice #(
  parameter int N     = 4,
  parameter int DW    = 32,
  parameter int OFF_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              req,
  input  logic [N-1:0]              req_we,
  input  logic [N-1:0][OFF_W-1:0]   req_off,
  input  logic [N-1:0][DW-1:0]      req_wdata,
  output logic [N-1:0]              grant,
  output logic                      bank_en,
  output logic                      bank_we,
  output logic [OFF_W-1:0]          bank_addr,
  output logic [DW-1:0]             bank_wdata
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     win_oh;
  logic [IDX_W-1:0] win_idx;
  logic             any;
  logic             win_store;
  logic [OFF_W-1:0] win_off;
  logic [N-1:0]     merge;

  bbx_rr_arbiter #(.N(N)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any     (any)
  );

  assign win_store = |(win_oh & req_we);
  assign win_off   = req_off[win_idx];

  // Reads that hit the winner's word ride along, unless the winner stores.
  always_comb begin
    for (int j = 0; j < N; j++) begin
      merge[j] = req[j] && !req_we[j] && !win_store && (req_off[j] == win_off);
    end
  end

  assign grant      = any ? (win_oh | merge) : '0;
  assign bank_en    = any;
  assign bank_we    = any && win_store;
  assign bank_addr  = win_off;
  assign bank_wdata = req_wdata[win_idx];
endmodule

// File: rtl/bcast_bank_xbar.sv
module bcast_bank_xbar #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N-1:0]                    core_valid,
  output logic [N-1:0]                    core_ready,
  input  logic [N-1:0]                    core_we,
  input  logic [N-1:0][AW-1:0]            core_addr,
  input  logic [N-1:0][DW-1:0]            core_wdata,
  output logic [N-1:0]                    rsp_valid,
  output logic [N-1:0][DW-1:0]            rsp_rdata,
  output logic [M-1:0]                    bank_en,
  output logic [M-1:0]                    bank_we,
  output logic [M-1:0][AW-2-$clog2(M):0]  bank_addr,
  output logic [M-1:0][DW-1:0]            bank_wdata,
  input  logic [M-1:0][DW-1:0]            bank_rdata,
  output logic [N-1:0]                    priv_en,
  output logic [N-1:0]                    priv_we,
  output logic [N-1:0][AW-2:0]            priv_addr,
  output logic [N-1:0][DW-1:0]            priv_wdata,
  input  logic [N-1:0][DW-1:0]            priv_rdata
);
  localparam int BANK_W = $clog2(M);
  localparam int SOFF_W = AW - 1 - BANK_W;

  logic [N-1:0]              is_priv;
  logic [N-1:0][BANK_W-1:0]  bank_idx;
  logic [N-1:0][SOFF_W-1:0]  shr_off;
  logic [N-1:0][AW-2:0]      prv_off;
  logic [M-1:0][N-1:0]       bank_grant;
  logic [N-1:0]              shr_grant;

  bbx_req_decode #(.N(N), .M(M), .AW(AW)) u_dec (
    .core_addr (core_addr),
    .is_priv   (is_priv),
    .bank_idx  (bank_idx),
    .shr_off   (shr_off),
    .prv_off   (prv_off)
  );

  for (genvar b = 0; b < M; b++) begin : g_bank
    logic [N-1:0] hit;
    always_comb begin
      for (int i = 0; i < N; i++) begin
        hit[i] = core_valid[i] && !is_priv[i] && (bank_idx[i] == BANK_W'(b));
      end
    end

    bbx_bank_slice #(.N(N), .DW(DW), .OFF_W(SOFF_W)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (hit),
      .req_we     (core_we),
      .req_off    (shr_off),
      .req_wdata  (core_wdata),
      .grant      (bank_grant[b]),
      .bank_en    (bank_en[b]),
      .bank_we    (bank_we[b]),
      .bank_addr  (bank_addr[b]),
      .bank_wdata (bank_wdata[b])
    );
  end

  always_comb begin
    shr_grant = '0;
    for (int b = 0; b < M; b++) begin
      shr_grant = shr_grant | bank_grant[b];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_core
    assign priv_en[i]    = core_valid[i] && is_priv[i];
    assign priv_we[i]    = priv_en[i] && core_we[i];
    assign priv_addr[i]  = prv_off[i];
    assign priv_wdata[i] = core_wdata[i];
    assign core_ready[i] = priv_en[i] || shr_grant[i];
    assign rsp_valid[i]  = core_ready[i] && !core_we[i];
    assign rsp_rdata[i]  = is_priv[i] ? priv_rdata[i] : bank_rdata[bank_idx[i]];
  end
endmodule

// File: rtl/bcast_bank_xbar_chk.sv
module bcast_bank_xbar_chk #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         core_valid,
  input logic [N-1:0]         core_ready,
  input logic [N-1:0]         core_we,
  input logic [N-1:0][AW-1:0] core_addr,
  input logic [N-1:0]         rsp_valid,
  input logic [N-1:0][DW-1:0] rsp_rdata,
  input logic [M-1:0]         bank_en
);
  localparam int BANK_W = $clog2(M);
  localparam int CW     = $clog2(N + 1) + 1;

  logic [N-1:0]         shr_gnt;
  logic [M-1:0][N-1:0]  gnt_on_bank;
  logic [N-1:0][CW-1:0] wait_cnt;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      shr_gnt[i] = core_ready[i] && !core_addr[i][AW-1];
    end
    for (int b = 0; b < M; b++) begin
      for (int i = 0; i < N; i++) begin
        gnt_on_bank[b][i] = shr_gnt[i] && (core_addr[i][BANK_W-1:0] == BANK_W'(b));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (core_valid[i] && !core_ready[i]) begin
          if (wait_cnt[i] != '1) wait_cnt[i] <= wait_cnt[i] + 1'b1;
        end else begin
          wait_cnt[i] <= '0;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_core
    p_ready_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      core_ready[i] |-> core_valid[i]);
    p_rsp_on_granted_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] |-> (core_ready[i] && !core_we[i]));
    p_private_never_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (core_valid[i] && core_addr[i][AW-1]) |-> core_ready[i]);
    p_bounded_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wait_cnt[i]) < N);
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      // R4, R6 and R7: co-granted cores on one bank must be reads of one word.
      p_one_word_per_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_gnt[i] && shr_gnt[j] &&
         (core_addr[i][BANK_W-1:0] == core_addr[j][BANK_W-1:0]))
        |-> (core_addr[i] == core_addr[j]) && !core_we[i] && !core_we[j]);
      p_broadcast_same_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_gnt[i] && shr_gnt[j] && (core_addr[i] == core_addr[j]))
        |-> (rsp_rdata[i] == rsp_rdata[j]));
    end
  end

  for (genvar b = 0; b < M; b++) begin : g_bank
    p_bank_en_tracks_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en[b] == (gnt_on_bank[b] != '0));
  end
endmodule

bind bcast_bank_xbar bcast_bank_xbar_chk #(.N(N), .M(M), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_valid (core_valid),
  .core_ready (core_ready),
  .core_we    (core_we),
  .core_addr  (core_addr),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .bank_en    (bank_en)
);

// File: tb/bcast_bank_xbar_tb.sv
`timescale 1ns/1ps
module bcast_bank_xbar_tb;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int SOFF_W = AW - 1 - $clog2(M);
  localparam int SDEPTH = 1 << SOFF_W;
  localparam int PDEPTH = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]              core_valid, core_ready, core_we, rsp_valid;
  logic [N-1:0][AW-1:0]      core_addr;
  logic [N-1:0][DW-1:0]      core_wdata, rsp_rdata;
  logic [M-1:0]              bank_en, bank_we;
  logic [M-1:0][SOFF_W-1:0]  bank_addr;
  logic [M-1:0][DW-1:0]      bank_wdata, bank_rdata;
  logic [N-1:0]              priv_en, priv_we;
  logic [N-1:0][AW-2:0]      priv_addr;
  logic [N-1:0][DW-1:0]      priv_wdata, priv_rdata;

  bcast_bank_xbar #(.N(N), .M(M), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_ready(core_ready), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .priv_en(priv_en), .priv_we(priv_we), .priv_addr(priv_addr),
    .priv_wdata(priv_wdata), .priv_rdata(priv_rdata)
  );

  // Memory models: combinational read, write at the clock edge.
  logic [DW-1:0] smem [M][SDEPTH];
  logic [DW-1:0] pmem [N][PDEPTH];

  for (genvar b = 0; b < M; b++) begin : g_sm
    assign bank_rdata[b] = smem[b][bank_addr[b]];
  end
  for (genvar c = 0; c < N; c++) begin : g_pm
    assign priv_rdata[c] = pmem[c][priv_addr[c]];
  end

  always @(posedge clk) begin
    for (int b = 0; b < M; b++)
      if (bank_en[b] && bank_we[b]) smem[b][bank_addr[b]] <= bank_wdata[b];
    for (int c = 0; c < N; c++)
      if (priv_en[c] && priv_we[c]) pmem[c][priv_addr[c]] <= priv_wdata[c];
  end

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [DW-1:0] sm_init(int b, int o);
    return 32'hB000_0000 | DW'(b << 8) | DW'(o);
  endfunction
  function automatic logic [AW-1:0] sh_a(int b, int o);
    return {1'b0, SOFF_W'(o), 2'(b)};
  endfunction
  function automatic logic [AW-1:0] pv_a(int o);
    return {1'b1, 7'(o)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    core_valid = '0; core_we = '0; core_addr = '0; core_wdata = '0;
  endtask

  task automatic put(int c, bit we, logic [AW-1:0] a, logic [DW-1:0] d);
    core_valid[c] = 1'b1; core_we[c] = we; core_addr[c] = a; core_wdata[c] = d;
  endtask

  task automatic drop(int c);
    core_valid[c] = 1'b0;
  endtask

  // Advance one cycle; inputs then settle before the next check.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_reqs();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    settle();
    chk("R10 ready idle", 64'(core_ready), 64'h0);
    chk("R10 rsp idle", 64'(rsp_valid), 64'h0);
    chk("R10 bank_en idle", 64'(bank_en), 64'h0);
    chk("R10 priv_en idle", 64'(priv_en), 64'h0);
  endtask

  task automatic t_decode();
    do_reset();
    put(2, 1'b0, sh_a(3, 22), '0);
    settle();
    chk("R1 bank select", 64'(bank_en), 64'h8);
    chk("R1 in-bank addr", 64'(bank_addr[3]), 64'd22);
    chk("R3 ready", 64'(core_ready), 64'h4);
    chk("R3 rsp strobe", 64'(rsp_valid), 64'h4);
    chk("R3 rsp data", 64'(rsp_rdata[2]), 64'(sm_init(3, 22)));
    clear_reqs();
  endtask

  task automatic t_parallel();
    do_reset();
    for (int c = 0; c < N; c++) put(c, 1'b0, sh_a(3 - c, c + 1), '0);
    settle();
    chk("R8 all ready", 64'(core_ready), 64'hF);
    chk("R8 all banks", 64'(bank_en), 64'hF);
    for (int c = 0; c < N; c++)
      chk("R8 data", 64'(rsp_rdata[c]), 64'(sm_init(3 - c, c + 1)));
    clear_reqs();
  endtask

  task automatic t_merge();
    do_reset();
    for (int c = 0; c < N; c++) put(c, 1'b0, sh_a(2, 9), '0);
    settle();
    chk("R6 full merge ready", 64'(core_ready), 64'hF);
    chk("R6 single access", 64'(bank_en), 64'h4);
    chk("R6 strobes", 64'(rsp_valid), 64'hF);
    for (int c = 0; c < N; c++)
      chk("R6 broadcast word", 64'(rsp_rdata[c]), 64'(sm_init(2, 9)));
    // Merge and arbitration on one bank in the same cycle.
    do_reset();
    put(0, 1'b0, sh_a(1, 3), '0);
    put(1, 1'b0, sh_a(1, 4), '0);
    put(2, 1'b0, sh_a(1, 3), '0);
    put(3, 1'b0, sh_a(1, 3), '0);
    settle();
    chk("R6 partial merge ready", 64'(core_ready), 64'hD);
    chk("R6 partial bank", 64'(bank_en), 64'h2);
    chk("R6 partial word c3", 64'(rsp_rdata[3]), 64'(sm_init(1, 3)));
    step();
    drop(0); drop(2); drop(3);
    settle();
    chk("R4 loser served next", 64'(core_ready), 64'h2);
    chk("R4 loser data", 64'(rsp_rdata[1]), 64'(sm_init(1, 4)));
    clear_reqs();
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int c = 0; c < 3; c++) put(c, 1'b0, sh_a(1, 10 + c), '0);
    settle();
    chk("R5 first from core0", 64'(core_ready), 64'h1);
    chk("R4 one at a time", 64'(bank_en), 64'h2);
    step(); drop(0); settle();
    chk("R5 then core1", 64'(core_ready), 64'h2);
    step(); drop(1); settle();
    chk("R9 core2 within N", 64'(core_ready), 64'h4);
    chk("R9 core2 data", 64'(rsp_rdata[2]), 64'(sm_init(1, 12)));
    step(); drop(2);
    put(0, 1'b0, sh_a(1, 13), '0);
    put(3, 1'b0, sh_a(1, 14), '0);
    settle();
    chk("R5 pointer past winner", 64'(core_ready), 64'h8);
    step(); drop(3); settle();
    chk("R5 wrap to core0", 64'(core_ready), 64'h1);
    step();
    put(0, 1'b0, sh_a(1, 15), '0);
    put(1, 1'b0, sh_a(1, 16), '0);
    settle();
    chk("R5 core1 after core0", 64'(core_ready), 64'h2);
    clear_reqs();
  endtask

  task automatic t_writes();
    do_reset();
    put(0, 1'b1, sh_a(0, 5), 32'hAAAA_0000);
    put(2, 1'b1, sh_a(0, 5), 32'hCCCC_0000);
    settle();
    chk("R7 store alone", 64'(core_ready), 64'h1);
    chk("R7 bank we", 64'(bank_we), 64'h1);
    chk("R7 store data", 64'(bank_wdata[0]), 64'h0000_0000_AAAA_0000);
    chk("R3 no rsp on store", 64'(rsp_valid), 64'h0);
    step(); drop(0); settle();
    chk("R7 second store", 64'(core_ready), 64'h4);
    chk("R7 second data", 64'(bank_wdata[0]), 64'h0000_0000_CCCC_0000);
    step(); drop(2);
    put(1, 1'b0, sh_a(0, 5), '0);
    put(3, 1'b0, sh_a(0, 5), '0);
    settle();
    chk("R7 readback ready", 64'(core_ready), 64'hA);
    chk("R7 readback last store", 64'(rsp_rdata[1]), 64'h0000_0000_CCCC_0000);
    clear_reqs();
    // Store wins against a read of the same word.
    do_reset();
    put(0, 1'b1, sh_a(0, 6), 32'h1234_5678);
    put(1, 1'b0, sh_a(0, 6), '0);
    settle();
    chk("R7 read not merged with store", 64'(core_ready), 64'h1);
    chk("R3 stalled read no rsp", 64'(rsp_valid), 64'h0);
    step(); drop(0); settle();
    chk("R7 read sees store", 64'(rsp_rdata[1]), 64'h0000_0000_1234_5678);
    clear_reqs();
    // Read wins; store to the same word waits, another read merges.
    do_reset();
    put(1, 1'b0, sh_a(0, 7), '0);
    put(2, 1'b1, sh_a(0, 7), 32'h0BAD_F00D);
    put(3, 1'b0, sh_a(0, 7), '0);
    settle();
    chk("R7 store stalls behind read", 64'(core_ready), 64'hA);
    chk("R7 old word", 64'(rsp_rdata[3]), 64'(sm_init(0, 7)));
    step(); drop(1); drop(3); settle();
    chk("R7 store proceeds", 64'(core_ready), 64'h4);
    clear_reqs();
  endtask

  task automatic t_private();
    do_reset();
    for (int c = 0; c < N; c++) put(c, 1'b1, pv_a(20), 32'h5000_0000 | DW'(c));
    settle();
    chk("R2 private ready", 64'(core_ready), 64'hF);
    chk("R2 no shared bank", 64'(bank_en), 64'h0);
    chk("R2 private enables", 64'(priv_en), 64'hF);
    chk("R2 private addr", 64'(priv_addr[3]), 64'd20);
    step();
    for (int c = 0; c < N; c++) put(c, 1'b0, pv_a(20), '0);
    settle();
    for (int c = 0; c < N; c++)
      chk("R2 private readback", 64'(rsp_rdata[c]), 64'(32'h5000_0000 | DW'(c)));
    clear_reqs();
    do_reset();
    put(0, 1'b0, pv_a(21), '0);
    put(1, 1'b0, sh_a(0, 1), '0);
    put(2, 1'b0, sh_a(0, 2), '0);
    settle();
    chk("R2 private beside conflict", 64'(core_ready), 64'h3);
    clear_reqs();
  endtask

  initial begin
    for (int b = 0; b < M; b++)
      for (int o = 0; o < SDEPTH; o++) smem[b][o] = sm_init(b, o);
    for (int c = 0; c < N; c++)
      for (int o = 0; o < PDEPTH; o++) pmem[c][o] = '0;
    clear_reqs();
    t_reset_state();
    t_decode();
    t_parallel();
    t_merge();
    t_round_robin();
    t_writes();
    t_private();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule